// File: doc/BRIEF.md
# Cache Line Interference Monitor

This block is a small tagged table that lets code reuse a loaded value speculatively and find out later whether that reuse was safe. A monitored load claims a slot by its tag and leaves behind the cache-line address it read from. From then on the table compares every incoming coherence event against the watched lines. A downgrade to shared or an invalidation of a watched line marks that slot as disturbed. The mark stays set until the slot is released or allocated again.

A check operation presents a mask with one bit per tag. In the same cycle the table reports whether any selected slot has been disturbed, so the code can decide whether to run the load again. A release frees a slot. The coherence protocol that produces the events, and the recovery code that acts on a failed check, are outside this block.

Top module: `line_watch_table`

## Requirements
- R1: After reset no slot is valid and a check with any mask reports no interference.
- R2: An allocation with `alloc_valid` high writes tag `alloc_tag` as valid and records the line of `alloc_addr`. Lines are compared with the low log2(LINE_BYTES) address bits dropped, so any byte offset within the same line matches.
- R3: A coherence event with `coh_valid` high and `coh_kind` equal to 2'b01 (downgrade to shared), 2'b10 or 2'b11 (invalidate) sets the interference flag of every valid slot whose line equals the event's line.
- R4: An event with `coh_kind` equal to 2'b00 (no loss of permission) has no effect on any flag. An event to a line that no valid slot watches also has no effect.
- R5: A set flag stays set through later events and checks until its tag is released or allocated again.
- R6: If an event arrives in the same cycle as an allocation and matches the newly allocated line, the new slot starts with its flag set. If the event matches only the tag's previous line, the new slot starts clear.
- R7: `chk_fail` is combinational and is high exactly when `chk_valid` is high and some tag selected in `chk_mask` is valid with its flag set. An all-zero mask therefore reports no interference.
- R8: A check sees the flags as they stood at the start of its cycle. An event in the same cycle becomes visible to checks from the next cycle on.
- R9: A release with `rel_valid` high clears both the valid bit and the flag of `rel_tag`. Later events on its old line do not set its flag.
- R10: If a release and an allocation name the same tag in the same cycle, the allocation wins and the slot is valid afterwards.
- R11: Allocating a tag that is already valid replaces its line and clears its flag, unless R6 applies.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Monitored load allocates a slot |
| alloc_tag | input | TAG_W | Tag of the slot to allocate |
| alloc_addr | input | ADDR_W | Byte address of the monitored load |
| coh_valid | input | 1 | Coherence event present |
| coh_addr | input | ADDR_W | Byte address of the coherence event |
| coh_kind | input | 2 | 00 keep, 01 downgrade, 10/11 invalidate |
| chk_valid | input | 1 | Check operation present |
| chk_mask | input | NUM_TAGS | One bit per tag selected by the check |
| chk_fail | output | 1 | Some selected slot saw interference |
| rel_valid | input | 1 | Release a slot |
| rel_tag | input | TAG_W | Tag of the slot to release |

## Verification
The bench builds the table with 16 tags, 32-bit addresses and 64-byte lines. Sixteen slots make full-mask, single-bit and empty masks cheap to cover. The random traffic also draws from a pool of only six lines, so slots often share a line, events often hit, and reallocations often collide with releases and events in the same cycle. Random byte offsets within each line test that the offset bits are ignored in the line compare.

// File: rtl/line_watch_table.sv
module line_watch_table #(
  parameter int NUM_TAGS   = 32,
  parameter int ADDR_W     = 48,
  parameter int LINE_BYTES = 64
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        alloc_valid,
  input  logic [$clog2(NUM_TAGS)-1:0] alloc_tag,
  input  logic [ADDR_W-1:0]           alloc_addr,
  input  logic                        coh_valid,
  input  logic [ADDR_W-1:0]           coh_addr,
  input  logic [1:0]                  coh_kind,
  input  logic                        chk_valid,
  input  logic [NUM_TAGS-1:0]         chk_mask,
  output logic                        chk_fail,
  input  logic                        rel_valid,
  input  logic [$clog2(NUM_TAGS)-1:0] rel_tag
);
  localparam int TAG_W  = $clog2(NUM_TAGS);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int LINE_W = ADDR_W - OFF_W;

  logic [NUM_TAGS-1:0] slot_vld;
  logic [NUM_TAGS-1:0] slot_flg;
  logic [LINE_W-1:0]   slot_line [NUM_TAGS];

  wire [LINE_W-1:0] new_line = alloc_addr[ADDR_W-1:OFF_W];
  wire [LINE_W-1:0] ev_line  = coh_addr[ADDR_W-1:OFF_W];
  wire              ev_act   = coh_valid && (coh_kind != 2'b00);
  wire              ev_new   = ev_act && (ev_line == new_line);

  for (genvar i = 0; i < NUM_TAGS; i++) begin : g_slot
    wire take = alloc_valid && (alloc_tag == TAG_W'(i));
    wire drop = rel_valid && (rel_tag == TAG_W'(i));
    wire hit  = ev_act && slot_vld[i] && (slot_line[i] == ev_line);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot_vld[i]  <= 1'b0;
        slot_flg[i]  <= 1'b0;
        slot_line[i] <= '0;
      end else if (take) begin
        slot_vld[i]  <= 1'b1;
        slot_flg[i]  <= ev_new;
        slot_line[i] <= new_line;
      end else if (drop) begin
        slot_vld[i]  <= 1'b0;
        slot_flg[i]  <= 1'b0;
      end else if (hit) begin
        slot_flg[i]  <= 1'b1;
      end
    end
  end

  assign chk_fail = chk_valid && |(chk_mask & slot_vld & slot_flg);
endmodule

// File: rtl/line_watch_table_chk.sv
module line_watch_table_chk #(
  parameter int NUM_TAGS = 32,
  parameter int TAG_W    = 5
) (
  input logic                clk,
  input logic                rst_n,
  input logic                alloc_valid,
  input logic [TAG_W-1:0]    alloc_tag,
  input logic                rel_valid,
  input logic [TAG_W-1:0]    rel_tag,
  input logic                chk_valid,
  input logic [NUM_TAGS-1:0] chk_mask,
  input logic                chk_fail,
  input logic [NUM_TAGS-1:0] slot_vld,
  input logic [NUM_TAGS-1:0] slot_flg
);
  logic [NUM_TAGS-1:0] touch;
  always_comb begin
    touch = '0;
    if (alloc_valid) touch[alloc_tag] = 1'b1;
    if (rel_valid)   touch[rel_tag]   = 1'b1;
  end

  // R7
  empty_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_mask == '0) |-> !chk_fail);

  // R7
  idle_check_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_valid |-> !chk_fail);

  // R2
  alloc_sets_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_valid |=> slot_vld[$past(alloc_tag)]);

  // R9
  release_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_valid && !(alloc_valid && alloc_tag == rel_tag))
      |=> !slot_vld[$past(rel_tag)] && !slot_flg[$past(rel_tag)]);

  // R5
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(slot_flg) & ~slot_flg & ~$past(touch)) == '0));

  // R9
  flag_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_flg & ~slot_vld) == '0);
endmodule

bind line_watch_table line_watch_table_chk #(.NUM_TAGS(NUM_TAGS), .TAG_W(TAG_W)) u_lwt_chk (
  .clk(clk), .rst_n(rst_n),
  .alloc_valid(alloc_valid), .alloc_tag(alloc_tag),
  .rel_valid(rel_valid), .rel_tag(rel_tag),
  .chk_valid(chk_valid), .chk_mask(chk_mask), .chk_fail(chk_fail),
  .slot_vld(slot_vld), .slot_flg(slot_flg)
);

// File: tb/line_watch_table_bench.sv
module line_watch_table_bench;
  localparam int NT = 16;
  localparam int AW = 32;
  localparam int LB = 64;
  localparam int TW = 4;
  localparam int OW = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic alloc_valid = 0, coh_valid = 0, chk_valid = 0, rel_valid = 0;
  logic [TW-1:0] alloc_tag = '0, rel_tag = '0;
  logic [AW-1:0] alloc_addr = '0, coh_addr = '0;
  logic [1:0]    coh_kind = '0;
  logic [NT-1:0] chk_mask = '0;
  logic          chk_fail;

  int tests = 0, fails = 0;
  bit done = 0;
  logic          m_vld [NT];
  logic          m_flg [NT];
  logic [AW-1:0] m_line[NT];
  logic [AW-1:0] pool [6];

  always #2 clk = ~clk;

  line_watch_table #(.NUM_TAGS(NT), .ADDR_W(AW), .LINE_BYTES(LB)) u_line_watch_table (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_tag(alloc_tag), .alloc_addr(alloc_addr),
    .coh_valid(coh_valid), .coh_addr(coh_addr), .coh_kind(coh_kind),
    .chk_valid(chk_valid), .chk_mask(chk_mask), .chk_fail(chk_fail),
    .rel_valid(rel_valid), .rel_tag(rel_tag));

  function automatic logic exp_fail(logic kv, logic [NT-1:0] mask);
    logic r = 1'b0;
    for (int i = 0; i < NT; i++) if (mask[i] && m_vld[i] && m_flg[i]) r = 1'b1;
    return kv && r;
  endfunction

  task automatic step(input logic av, input logic [TW-1:0] at, input logic [AW-1:0] aa,
                      input logic cv, input logic [AW-1:0] ca, input logic [1:0] ck,
                      input logic rv, input logic [TW-1:0] rt,
                      input logic kv, input logic [NT-1:0] km, input string req);
    logic exp;
    logic ev;
    @(negedge clk);
    alloc_valid = av; alloc_tag = at; alloc_addr = aa;
    coh_valid = cv; coh_addr = ca; coh_kind = ck;
    rel_valid = rv; rel_tag = rt; chk_valid = kv; chk_mask = km;
    #1;
    exp = exp_fail(kv, km);
    tests++;
    if (chk_fail !== exp) begin
      fails++;
      $display("FAIL %s: chk_fail=%0b expected %0b", req, chk_fail, exp);
    end
    @(posedge clk);
    ev = cv && (ck != 2'b00);
    for (int i = 0; i < NT; i++) begin
      if (av && at == TW'(i)) begin
        m_vld[i] = 1'b1; m_line[i] = aa >> OW;
        m_flg[i] = ev && ((ca >> OW) == (aa >> OW));
      end else if (rv && rt == TW'(i)) begin
        m_vld[i] = 1'b0; m_flg[i] = 1'b0;
      end else if (ev && m_vld[i] && m_line[i] == (ca >> OW)) begin
        m_flg[i] = 1'b1;
      end
    end
  endtask

  task automatic probe(input logic [NT-1:0] km, input string req);
    step(0, '0, '0, 0, '0, 2'b00, 0, '0, 1, km, req);
  endtask

  initial begin
    for (int i = 0; i < NT; i++) begin m_vld[i] = 0; m_flg[i] = 0; m_line[i] = '0; end
    for (int i = 0; i < 6; i++) pool[i] = 32'h1000_0000 + i * LB * 3;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R1 reset state
    probe('1, "R1");
    // R2 R3 alloc then downgrade at different offset within line
    step(1, 4'd3, pool[0] + 5, 0, '0, 2'b00, 0, '0, 0, '0, "R2");
    step(0, '0, '0, 1, pool[0] + 60, 2'b01, 0, '0, 1, 16'h0008, "R8");
    probe(16'h0008, "R3");
    // R4 kind 00 and other line ignored
    step(1, 4'd5, pool[1], 1, pool[1] + 8, 2'b00, 0, '0, 0, '0, "R4");
    step(0, '0, '0, 1, pool[2], 2'b10, 0, '0, 1, 16'h0020, "R4");
    probe(16'h0020, "R4");
    // R7 empty mask and idle check
    probe('0, "R7");
    step(0, '0, '0, 0, '0, 2'b00, 0, '0, 0, '1, "R7");
    // R5 flag persists through events and checks
    step(0, '0, '0, 1, pool[0], 2'b00, 0, '0, 1, 16'h0008, "R5");
    probe(16'hFFFF, "R5");
    // R9 release clears, later invalidate ignored
    step(0, '0, '0, 0, '0, 2'b00, 1, 4'd3, 0, '0, "R9");
    step(0, '0, '0, 1, pool[0], 2'b11, 0, '0, 1, 16'h0008, "R9");
    probe(16'h0008, "R9");
    // R6 same-cycle event on new line
    step(1, 4'd7, pool[3] + 1, 1, pool[3] + 40, 2'b10, 0, '0, 0, '0, "R6");
    probe(16'h0080, "R6");
    // R11 realloc clears flag; R6 event on old line only
    step(1, 4'd7, pool[4], 1, pool[3], 2'b01, 0, '0, 1, 16'h0080, "R11");
    probe(16'h0080, "R11");
    // R10 alloc beats release
    step(1, 4'd9, pool[5], 0, '0, 2'b00, 1, 4'd9, 0, '0, "R10");
    step(0, '0, '0, 1, pool[5], 2'b01, 0, '0, 0, '0, "R10");
    probe(16'h0200, "R10");
    // random traffic
    void'($urandom(32'd1357));
    for (int n = 0; n < 3000; n++) begin
      logic av, cv, rv, kv;
      logic [NT-1:0] km;
      av = ($urandom % 3) == 0;
      cv = ($urandom % 2) == 0;
      rv = ($urandom % 5) == 0;
      kv = ($urandom % 4) != 0;
      km = NT'($urandom);
      if (($urandom % 8) == 0) km = '0;
      step(av, TW'($urandom), pool[$urandom % 6] + ($urandom % LB),
           cv, pool[$urandom % 6] + ($urandom % LB), 2'($urandom),
           rv, TW'($urandom), kv, km, "R3/R7 random");
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: run did not complete");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule